// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital controller for a multi-channel successive-approximation converter. Software sets it up over a small register bus. It waits for one chosen start source, either a software write or one of several hardware trigger lines. It then walks through a contiguous range of input channels. For each channel it first holds a sampling window, then resolves the result one bit per clock from a single comparator bit, most significant bit first.

The analog front end is outside the block. `muxSel` steers the analog input multiplexer. `sampling` tells the track-and-hold when to track. During conversion, `sarCode` carries the trial code for the DAC, and `compIn` returns the comparator decision: 1 when the input is at or above the trial code. Each finished result is loaded into a data register. Loading a result sets a ready flag and pulses an interrupt. If the result replaces one that was never read, a sticky overwrite flag is also set.

In single-pass mode the range is converted once. In repeating mode the sequence wraps to the first channel until software stops it.

Top module: `adcSeq`

## Requirements
- R1: The sampling window lasts 3, 5, 7 or 9 clocks for sample-time codes 0, 1, 2 and 3 (CTRL bits 6:5). `sampling` is high for exactly those cycles, and conversion follows at once.
- R2: After reset the sample-time code is 3, so CTRL reads 0x0060. Every other register field is 0.
- R3: While the enable bit (CTRL bit 0) is 0, neither a start write nor any hardware trigger starts a sequence.
- R4: With trigger select 0 and enable already 1, writing CTRL with bit 1 set starts a sequence on the next cycle. CTRL bit 1 reads 1 while a sequence is busy.
- R5: Trigger select codes 1 to 3 (CTRL bits 4:3) accept only `hwTrig[code-1]`. The other lines are ignored, and so is a start write.
- R6: Channels are converted in ascending order, modulo 8, from RANGE bits 2:0 up to RANGE bits 5:3. `muxSel` shows the active channel.
- R7: Conversion takes 10 clocks. During the cycle that decides bit b, `sarCode` equals the bits already decided with bit b set, and `compIn` decides that bit. `sarCode` is 0 outside conversion. The 10-bit result appears in DATA (address 2).
- R8: In single-pass mode (CTRL bit 2 = 0) each channel in the range is converted once. The busy bit clears in the cycle after the last result is written.
- R9: In repeating mode (CTRL bit 2 = 1) the sequence restarts at the first channel. A CTRL write with bit 0 or bit 1 clear, made while busy, stops the sequence at once, and the conversion in flight writes no result and raises no interrupt.
- R10: Writing a result sets the ready flag (STATUS bit 0) and raises `irq` for exactly one cycle. A bus read of DATA clears the ready flag.
- R11: A result written while the ready flag is 1, and DATA is not being read in the same cycle, sets the overwrite flag (STATUS bit 1). That flag stays set until a write to STATUS with bit 1 set clears it, and setting wins over clearing in the same cycle.
- R12: Register addresses are CTRL 0, RANGE 1, DATA 2 and STATUS 3. `busRData` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe; clears the ready flag when addressing DATA |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data of the addressed register |
| hwTrig | input | 3 | Hardware trigger lines, level sampled while idle |
| compIn | input | 1 | Comparator result for the current trial code |
| muxSel | output | 3 | Active channel number |
| sampling | output | 1 | High during the sampling window |
| sarCode | output | 10 | Trial code for the DAC during conversion |
| irq | output | 1 | One-cycle pulse when a result is written |

## Verification
A result commit can land in the same clock as a bus read of DATA. The same is true of a write that clears the overwrite flag. The bench uses its own cycle model to predict the commit cycle, and drives the competing bus access into exactly that clock. It then checks the rules: a same-cycle read leaves the ready flag set without flagging an overwrite, and a same-cycle clear loses to a new overwrite. A stop request is also issued in the middle of a conversion, to confirm that the interrupted result never reaches DATA.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RANGE  = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic sampleLast; // final sampling cycle: clear the trial code
    logic convStep;   // one bit is decided this cycle
    logic commit;     // last bit decided and not aborted
  } seqStrobe_t;
endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int CH_W        = 3,
  parameter int NUM_HW_TRIG = 3,
  localparam int TSEL_W     = $clog2(NUM_HW_TRIG + 1),
  localparam int CFG_W      = 5 + TSEL_W,
  localparam int IDX_W      = $clog2(RES_BITS),
  localparam int CNT_W      = $clog2(RES_BITS + 10)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrCtrl,
  input  logic                   wrRange,
  input  logic [CFG_W-1:0]       cfgWData,
  input  logic [2*CH_W-1:0]      rangeWData,
  input  logic [NUM_HW_TRIG-1:0] hwTrig,
  output logic                   cfgEnable,
  output logic                   cfgMode,
  output logic [TSEL_W-1:0]      cfgTrigSel,
  output logic [1:0]             cfgSampleTime,
  output logic [CH_W-1:0]        cfgStartCh,
  output logic [CH_W-1:0]        cfgEndCh,
  output logic                   busy,
  output logic [CH_W-1:0]        muxSel,
  output logic [IDX_W-1:0]       bitIdx,
  output seqStrobe_t             strobes
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chan;
  logic [CNT_W-1:0] lastSample;
  logic [NUM_HW_TRIG:0] trigVec;
  logic trigHit, abortReq, lastBit;

  // window length 2*code+3, last count value 2*code+2
  assign lastSample = CNT_W'({cfgSampleTime, 1'b1}) + CNT_W'(1);
  assign trigVec    = {hwTrig, wrCtrl & cfgWData[1]};
  assign trigHit    = trigVec[cfgTrigSel];
  assign busy       = (phase != PH_IDLE);
  assign abortReq   = wrCtrl && busy && !(cfgWData[0] && cfgWData[1]);
  assign lastBit    = (phase == PH_CONVERT) && (cnt == '0);

  always_comb begin
    strobes.sampleLast = (phase == PH_SAMPLE) && (cnt == lastSample);
    strobes.convStep   = (phase == PH_CONVERT);
    strobes.commit     = lastBit && !abortReq;
  end

  assign muxSel = chan;
  assign bitIdx = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      chan  <= '0;
    end else if (abortReq) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (cfgEnable && trigHit) begin
          phase <= PH_SAMPLE;
          cnt   <= '0;
          chan  <= cfgStartCh;
        end
        PH_SAMPLE: if (strobes.sampleLast) begin
          phase <= PH_CONVERT;
          cnt   <= CNT_W'(RES_BITS - 1);
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_CONVERT: if (lastBit) begin
          cnt <= '0;
          if (chan != cfgEndCh) begin
            chan  <= chan + 1'b1;
            phase <= PH_SAMPLE;
          end else if (cfgMode) begin
            chan  <= cfgStartCh;
            phase <= PH_SAMPLE;
          end else begin
            phase <= PH_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // configuration fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable     <= 1'b0;
      cfgMode       <= 1'b0;
      cfgTrigSel    <= '0;
      cfgSampleTime <= 2'b11;
      cfgStartCh    <= '0;
      cfgEndCh      <= '0;
    end else begin
      if (wrCtrl) begin
        cfgEnable     <= cfgWData[0];
        cfgMode       <= cfgWData[2];
        cfgTrigSel    <= cfgWData[3 +: TSEL_W];
        cfgSampleTime <= cfgWData[3 + TSEL_W +: 2];
      end
      if (wrRange) begin
        cfgStartCh <= rangeWData[CH_W-1:0];
        cfgEndCh   <= rangeWData[2*CH_W-1:CH_W];
      end
    end
  end
endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int RES_BITS = 10,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobes,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                compIn,
  input  logic                rdData,
  input  logic                clrOvr,
  output logic [RES_BITS-1:0] sarCode,
  output logic [RES_BITS-1:0] resultReg,
  output logic                doneFlag,
  output logic                ovrFlag,
  output logic                irq
);
  logic [RES_BITS-1:0] code, trialBit, trial, codeNext;

  assign trialBit = RES_BITS'(1) << bitIdx;
  assign trial    = code | trialBit;
  assign codeNext = compIn ? trial : code;
  assign sarCode  = strobes.convStep ? trial : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code      <= '0;
      resultReg <= '0;
      doneFlag  <= 1'b0;
      ovrFlag   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= strobes.commit;
      if (strobes.sampleLast) code <= '0;
      else if (strobes.convStep) code <= codeNext;

      if (strobes.commit) begin
        resultReg <= codeNext;
        doneFlag  <= 1'b1;
      end else if (rdData) begin
        doneFlag  <= 1'b0;
      end

      if (strobes.commit && doneFlag && !rdData) ovrFlag <= 1'b1;
      else if (clrOvr) ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/adcSeq.sv
module adcSeq
  import adcSeqPkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int CH_W        = 3,
  parameter int NUM_HW_TRIG = 3,
  parameter int DATA_W      = 16,
  localparam int TSEL_W     = $clog2(NUM_HW_TRIG + 1),
  localparam int CFG_W      = 5 + TSEL_W,
  localparam int IDX_W      = $clog2(RES_BITS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             busAddr,
  input  logic                   busWrite,
  input  logic                   busRead,
  input  logic [DATA_W-1:0]      busWData,
  output logic [DATA_W-1:0]      busRData,
  input  logic [NUM_HW_TRIG-1:0] hwTrig,
  input  logic                   compIn,
  output logic [CH_W-1:0]        muxSel,
  output logic                   sampling,
  output logic [RES_BITS-1:0]    sarCode,
  output logic                   irq
);
  seqStrobe_t          strobes;
  logic                cfgEnable, cfgMode, busy, doneFlag, ovrFlag, converting;
  logic [TSEL_W-1:0]   cfgTrigSel;
  logic [1:0]          cfgSampleTime;
  logic [CH_W-1:0]     cfgStartCh, cfgEndCh;
  logic [IDX_W-1:0]    bitIdx;
  logic [RES_BITS-1:0] resultReg;
  logic                wrCtrl, wrRange, rdData, clrOvr;
  logic                unusedWData;

  assign wrCtrl      = busWrite && (busAddr == ADDR_CTRL);
  assign wrRange     = busWrite && (busAddr == ADDR_RANGE);
  assign rdData      = busRead  && (busAddr == ADDR_DATA);
  assign clrOvr      = busWrite && (busAddr == ADDR_STATUS) && busWData[1];
  assign unusedWData = ^busWData[DATA_W-1:CFG_W];
  assign sampling    = strobes.sampleLast | (busy & ~strobes.convStep);
  assign converting  = strobes.convStep;

  adcSeqCtrl #(.RES_BITS(RES_BITS), .CH_W(CH_W), .NUM_HW_TRIG(NUM_HW_TRIG)) u_ctrl (
    .clk, .rstN, .wrCtrl, .wrRange,
    .cfgWData(busWData[CFG_W-1:0]), .rangeWData(busWData[2*CH_W-1:0]),
    .hwTrig, .cfgEnable, .cfgMode, .cfgTrigSel, .cfgSampleTime,
    .cfgStartCh, .cfgEndCh, .busy, .muxSel, .bitIdx, .strobes
  );

  adcSeqDatapath #(.RES_BITS(RES_BITS)) u_dp (
    .clk, .rstN, .strobes, .bitIdx, .compIn, .rdData, .clrOvr,
    .sarCode, .resultReg, .doneFlag, .ovrFlag, .irq
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:   busRData = DATA_W'({cfgSampleTime, cfgTrigSel, cfgMode, busy, cfgEnable});
      ADDR_RANGE:  busRData = DATA_W'({cfgEndCh, cfgStartCh});
      ADDR_DATA:   busRData = DATA_W'(resultReg);
      default:     busRData = DATA_W'({ovrFlag, doneFlag});
    endcase
  end
endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            irq,
  input logic            doneFlag,
  input logic            ovrFlag,
  input logic            clrOvr,
  input logic            cfgEnable,
  input logic            busy,
  input logic            converting,
  input logic [CH_W-1:0] muxSel
);
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq);
  // R10
  irq_done_chk: assert property (@(posedge clk) disable iff (!rstN) irq |-> doneFlag);
  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) ovrFlag && !clrOvr |=> ovrFlag);
  // R3
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rstN) !cfgEnable && !busy |=> !busy);
  // R6
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rstN) converting && $past(converting) |-> $stable(muxSel));
endmodule

bind adcSeq adcSeqChecker #(.CH_W(CH_W)) u_adcSeqChecker (
  .clk(clk), .rstN(rstN), .irq(irq), .doneFlag(doneFlag), .ovrFlag(ovrFlag),
  .clrOvr(clrOvr), .cfgEnable(cfgEnable), .busy(busy), .converting(converting),
  .muxSel(muxSel)
);

// File: tb/adcSeq_bench.sv
module adcSeq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic [2:0]  hwTrig = '0;
  logic        compIn, sampling, irq;
  logic [2:0]  muxSel;
  logic [9:0]  sarCode;

  int analog [8] = '{100, 1023, 517, 0, 700, 333, 900, 64};
  int checks = 0, fails = 0, irqCount = 0;
  int chanLog [$];
  bit prevSampling = 0, finished = 0;

  always #2 clk = ~clk; // 250 MHz

  assign compIn = (analog[muxSel] >= int'(sarCode));

  adcSeq u_adcSeq (
    .clk, .rstN, .busAddr, .busWrite, .busRead, .busWData, .busRData,
    .hwTrig, .compIn, .muxSel, .sampling, .sarCode, .irq
  );

  // behavioural reference: phase 0 idle, 1 sampling, 2 converting
  int mPhase, mCnt, mCh, mCode, mData, mTs, mSt, mStartCh, mEndCh;
  bit mEn, mMode, mDone, mOvr, mIrq;
  bit wrC, abortR, commit, trig, rdD, w1c;
  int trial, newCode;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mCh = 0; mCode = 0; mData = 0; mTs = 0; mSt = 3;
      mStartCh = 0; mEndCh = 0; mEn = 0; mMode = 0; mDone = 0; mOvr = 0; mIrq = 0;
    end else begin
      wrC    = busWrite && busAddr == 0;
      abortR = wrC && mPhase != 0 && !(busWData[0] && busWData[1]);
      commit = mPhase == 2 && mCnt == 0 && !abortR;
      trig   = (mTs == 0) ? (wrC && busWData[1]) : hwTrig[mTs-1];
      rdD    = busRead && busAddr == 2;
      w1c    = busWrite && busAddr == 3 && busWData[1];
      trial  = mCode | (1 << mCnt);
      newCode = (analog[mCh] >= trial) ? trial : mCode;
      mIrq = commit;
      if (commit && mDone && !rdD) mOvr = 1;
      else if (w1c) mOvr = 0;
      if (commit) begin mDone = 1; mData = newCode; end
      else if (rdD) mDone = 0;
      if (abortR) mPhase = 0;
      else if (mPhase == 0) begin
        if (mEn && trig) begin mPhase = 1; mCnt = 0; mCh = mStartCh; end
      end else if (mPhase == 1) begin
        if (mCnt == 2 + 2 * mSt) begin mPhase = 2; mCnt = 9; mCode = 0; end
        else mCnt++;
      end else begin
        mCode = newCode;
        if (mCnt == 0) begin
          mCnt = 0;
          if (mCh != mEndCh) begin mCh = (mCh + 1) % 8; mPhase = 1; end
          else if (mMode) begin mCh = mStartCh; mPhase = 1; end
          else mPhase = 0;
        end else mCnt--;
      end
      if (wrC) begin
        mEn = busWData[0]; mMode = busWData[2]; mTs = busWData[4:3]; mSt = busWData[6:5];
      end
      if (busWrite && busAddr == 1) begin
        mStartCh = busWData[2:0]; mEndCh = busWData[5:3];
      end
    end
  end

  function automatic int modelRead(int a);
    case (a)
      0: return (mSt << 5) | (mTs << 3) | (int'(mMode) << 2) | (int'(mPhase != 0) << 1) | int'(mEn);
      1: return (mEndCh << 3) | mStartCh;
      2: return mData;
      default: return (int'(mOvr) << 1) | int'(mDone);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1 sampling", int'(sampling), int'(mPhase == 1));
    chk("R6 muxSel", int'(muxSel), mCh);
    chk("R7 sarCode", int'(sarCode), (mPhase == 2) ? (mCode | (1 << mCnt)) : 0);
    chk("R10 irq", int'(irq), int'(mIrq));
    chk("R12 busRData", int'(busRData), modelRead(int'(busAddr)));
    if (irq) irqCount++;
    if (sampling && !prevSampling) chanLog.push_back(int'(muxSel));
    prevSampling = sampling;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(int a, int d);
    busAddr = 2'(a); busWData = 16'(d); busWrite = 1'b1;
    tick();
    busWrite = 1'b0;
  endtask

  task automatic rd(int a);
    busAddr = 2'(a); busRead = 1'b1;
    tick();
    busRead = 1'b0;
  endtask

  function automatic int peek(int a);
    busAddr = 2'(a);
    return modelRead(a) * 0 + 0;
  endfunction

  task automatic look(int a, output int v);
    busAddr = 2'(a);
    #1 v = int'(busRData);
  endtask

  task automatic waitIdle();
    while (mPhase != 0) tick();
  endtask

  task automatic waitCommitCycle();
    while (!(mPhase == 2 && mCnt == 0)) tick();
  endtask

  function automatic int ctl(int en, int st, int mode, int ts, int smp);
    return (smp << 5) | (ts << 3) | (mode << 2) | (st << 1) | en;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int v, irqBefore, dataBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // reset state
    look(0, v); chk("R2 ctrl reset", v, 'h60);
    look(1, v); chk("R12 range reset", v, 0);
    look(2, v); chk("R12 data reset", v, 0);
    look(3, v); chk("R12 status reset", v, 0);

    // disabled: start write and triggers ignored
    wr(0, ctl(0, 1, 0, 0, 0));
    hwTrig = 3'b111; tick(); tick(); hwTrig = '0;
    look(0, v); chk("R3 busy while disabled", (v >> 1) & 1, 0);

    // single-pass, channels 2..4, shortest window
    wr(1, (4 << 3) | 2);
    wr(0, ctl(1, 0, 0, 0, 0));
    chanLog.delete();
    wr(0, ctl(1, 1, 0, 0, 0));
    look(0, v); chk("R4 busy readback", (v >> 1) & 1, 1);
    waitIdle();
    tick();
    chk("R6 channel count", chanLog.size(), 3);
    for (int i = 0; i < 3 && i < chanLog.size(); i++) chk("R6 channel order", chanLog[i], 2 + i);
    look(0, v); chk("R8 busy cleared", (v >> 1) & 1, 0);
    look(2, v); chk("R7 result", v, analog[4]);
    look(3, v); chk("R11 overwrite set", v, 3);
    wr(3, 2);
    look(3, v); chk("R11 overwrite cleared", v, 1);
    rd(2);
    look(3, v); chk("R10 ready cleared by read", v & 1, 0);

    // hardware trigger select 2, channel 5, window code 1
    wr(1, (5 << 3) | 5);
    wr(0, ctl(1, 0, 0, 2, 1));
    hwTrig = 3'b001; tick(); hwTrig = '0;
    look(0, v); chk("R5 wrong line ignored", (v >> 1) & 1, 0);
    wr(0, ctl(1, 1, 0, 2, 1));
    look(0, v); chk("R5 start write ignored", (v >> 1) & 1, 0);
    hwTrig = 3'b010; tick(); hwTrig = '0;
    look(0, v); chk("R5 selected line starts", (v >> 1) & 1, 1);
    waitIdle();
    tick();
    look(2, v); chk("R7 result ch5", v, analog[5]);
    look(3, v); chk("R10 ready set", v, 1);

    // read of DATA in the commit cycle
    hwTrig = 3'b010; tick(); hwTrig = '0;
    waitCommitCycle();
    rd(2);
    look(3, v); chk("R11 read at commit keeps ready, no overwrite", v, 1);

    // clear of overwrite in the cycle a new overwrite occurs
    hwTrig = 3'b010; tick(); hwTrig = '0;
    waitCommitCycle();
    wr(3, 2);
    look(3, v); chk("R11 set wins over clear", v, 3);

    // repeating mode, range 7 to 1 wraps through 0, window code 3
    wr(3, 2);
    rd(2);
    wr(1, (1 << 3) | 7);
    wr(0, ctl(1, 0, 1, 0, 3));
    chanLog.delete();
    irqBefore = irqCount;
    wr(0, ctl(1, 1, 1, 0, 3));
    while (irqCount - irqBefore < 5) tick();
    while (!(mPhase == 2 && mCnt == 4)) tick();
    look(2, dataBefore);
    irqBefore = irqCount;
    wr(0, ctl(1, 0, 1, 0, 3));
    look(0, v); chk("R9 stop clears busy", (v >> 1) & 1, 0);
    repeat (40) tick();
    chk("R9 no irq after stop", irqCount - irqBefore, 0);
    look(2, v); chk("R9 aborted result discarded", v, dataBefore);
    chk("R9 pass count", int'(chanLog.size() >= 5), 1);
    for (int i = 0; i < 5 && i < chanLog.size(); i++)
      chk("R9 wrap order", chanLog[i], (i % 3 == 0) ? 7 : (i % 3 == 1) ? 0 : 1);
    v = peek(0);
    finish();
  end
endmodule